// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block takes one USB transfer descriptor, as its control word and token word, together with the result of the device transaction that the descriptor started. It works out the descriptor's new control word. It also decodes the token into packet ID, device address, endpoint and maximum byte count. From the result it derives a two-bit interrupt-cause mask and a three-way outcome that tells the list walker what to do next: move on (advance), leave the queue where it is (hold), or stop the current frame (abort).

The caller presents one descriptor per cycle with `in_valid`. One register stage later the block returns the updated control word and a flag that says whether the word differs from the input, so the descriptor is written back only when needed. It also returns the host-error and USB-error flags that the caller raises. Each descriptor carries a small retry budget in its control word. Timeouts use it up, and when it runs out the descriptor is retired with an error. A budget of zero means retries are unlimited.

Top module: `tdu_status_update`

## Requirements
- R1: The token is decoded as packet ID in bits [7:0], device address in [14:8] and endpoint in [18:15]. The packet IDs recognised are OUT 0xE1, IN 0x69 and SETUP 0x2D.
- R2: The maximum byte count is (token[31:21] + 1) mod 2048, so a field of 0x7FF gives zero bytes.
- R3: Control bit 24 (interrupt on completion) sets `int_mask[0]` for every descriptor presented, whether it is active or not.
- R4: If control bit 23 (active) is clear, `ctrl_out` equals `ctrl_in`, `ctrl_changed` is 0 and `outcome` is hold (2'd1).
- R5: An active descriptor whose packet ID is not OUT, IN or SETUP raises `host_err`, leaves the control word unchanged and gives outcome abort (2'd2).
- R6: On a successful transfer, control bits [10:0] are loaded with (bytes moved − 1) mod 2048 and active is cleared. OUT and SETUP move the maximum byte count; IN moves the reported length. Result code 3'd0 means data.
- R7: An IN that succeeds with short-packet detect (bit 29) set and fewer bytes than the maximum sets `int_mask[1]` and gives hold. Every other success gives advance (2'd0).
- R8: An IN reply longer than the maximum, or result code 3'd4 (babble), sets bits 20 and 22, clears active and gives abort.
- R9: Result code 3'd3 (no device), or any code from 3'd5 to 3'd7, is a timeout. It sets bit 18 and gives hold. A nonzero retry count in bits [28:27] is decremented, and on reaching zero active is cleared and `usb_err` is raised. A count of zero stays zero.
- R10: Result code 3'd1 (NAK) sets bit 19 and gives hold. On a SETUP token the timeout handling of R9 is applied as well.
- R11: Result code 3'd2 (stall) sets bit 22, clears active and gives hold.
- R12: With isochronous select (bit 25) set, an active descriptor with a valid packet ID always leaves with active cleared.
- R13: `ctrl_changed` is 1 exactly when `ctrl_out` differs from the `ctrl_in` it was computed from.
- R14: All outputs are registered. `out_valid` follows `in_valid` by one clock, and a synchronous active-low reset clears `out_valid` and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A descriptor and its result are presented |
| ctrl_in | input | 32 | Descriptor control word |
| token_in | input | 32 | Descriptor token word |
| res_kind | input | 3 | Transaction result code |
| res_len | input | 12 | Bytes returned by the device for IN |
| out_valid | output | 1 | Outputs hold a result |
| ctrl_out | output | 32 | Updated control word |
| ctrl_changed | output | 1 | ctrl_out differs from ctrl_in |
| int_mask | output | 2 | Bit 0 completion, bit 1 short packet |
| outcome | output | 2 | 0 advance, 1 hold, 2 abort |
| host_err | output | 1 | Invalid packet ID seen |
| usb_err | output | 1 | Retry budget exhausted |
| pid | output | 8 | Decoded packet ID |
| dev_addr | output | 7 | Decoded device address |
| endp | output | 4 | Decoded endpoint |
| max_bytes | output | 11 | Decoded maximum byte count |

## Verification
Successful transfers are run with OUT, with IN at full length, with IN short with and without short-packet detect, and with a zero-byte maximum. Together these separate the advance path from the hold path and check the length wrap at both ends. Timeouts are run at retry counts of three, one and zero, and a NAK is run on both IN and SETUP, which shows where the counter saturates and where the retry budget is spent. Stall, babble, an over-length IN, isochronous select and a bad packet ID each reach a different combination of outcome and error flag. Inactive descriptors with the completion bit set show that the mask is raised independently of any update.

// File: rtl/tdu_pkg.sv
// Package: shared constants and types for the descriptor status updater.
// Assumes a 32-bit control word with the bit positions listed here.
package tdu_pkg;
    localparam int CTRL_W     = 32;
    localparam int LEN_W      = 11;
    localparam int B_TMO      = 18;
    localparam int B_NAK      = 19;
    localparam int B_BABBLE   = 20;
    localparam int B_STALL    = 22;
    localparam int B_ACTIVE   = 23;
    localparam int B_IOC      = 24;
    localparam int B_ISO      = 25;
    localparam int B_ERR_LO   = 27;
    localparam int B_ERR_HI   = 28;
    localparam int B_SPD      = 29;

    localparam logic [7:0] PID_OUT   = 8'hE1;
    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_SETUP = 8'h2D;

    typedef enum logic [2:0] {
        RES_DATA   = 3'd0,
        RES_NAK    = 3'd1,
        RES_STALL  = 3'd2,
        RES_NODEV  = 3'd3,
        RES_BABBLE = 3'd4
    } res_kind_e;

    typedef enum logic [1:0] {
        OC_ADVANCE = 2'd0,
        OC_HOLD    = 2'd1,
        OC_ABORT   = 2'd2
    } outcome_e;

    typedef enum logic [1:0] {
        PK_OUT   = 2'd0,
        PK_IN    = 2'd1,
        PK_SETUP = 2'd2,
        PK_BAD   = 2'd3
    } pid_class_e;

    typedef enum logic [2:0] {
        EV_OK      = 3'd0,
        EV_NAK     = 3'd1,
        EV_STALL   = 3'd2,
        EV_TIMEOUT = 3'd3,
        EV_BABBLE  = 3'd4
    } event_e;
endpackage

// File: rtl/tdu_token_decode.sv
// Token decoder: splits the token word into its fields and classifies the
// packet ID. Assumes the fixed field layout of the token word.
module tdu_token_decode
    import tdu_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic [31:0]    token,
    output logic [7:0]     pid,
    output logic [6:0]     dev_addr,
    output logic [3:0]     endp,
    output logic [LW-1:0]  max_bytes,
    output pid_class_e     pclass
);
    logic [LW-1:0] len_field;

    // Field extraction; the byte count wraps at 2**LW.
    always_comb begin
        pid       = token[7:0];
        dev_addr  = token[14:8];
        endp      = token[18:15];
        len_field = token[31:32-LW];
        max_bytes = len_field + LW'(1);
    end

    // Packet ID classification.
    always_comb begin
        case (pid)
            PID_OUT:   pclass = PK_OUT;
            PID_IN:    pclass = PK_IN;
            PID_SETUP: pclass = PK_SETUP;
            default:   pclass = PK_BAD;
        endcase
    end
endmodule

// File: rtl/tdu_result_eval.sv
// Result evaluator: turns the device result code and returned length into
// a single event and the number of bytes actually moved. Assumes res_len is
// meaningful only for IN data results.
module tdu_result_eval
    import tdu_pkg::*;
#(
    parameter int LW  = LEN_W,
    parameter int RLW = 12
) (
    input  pid_class_e      pclass,
    input  logic [2:0]      res_kind,
    input  logic [RLW-1:0]  res_len,
    input  logic [LW-1:0]   max_bytes,
    output event_e          ev,
    output logic [LW-1:0]   xfer_len
);
    localparam int CW = (RLW > LW) ? RLW : LW;
    logic [CW-1:0] len_w;
    logic [CW-1:0] max_w;

    // Common-width copies for the over-length compare.
    always_comb begin
        len_w = CW'(res_len);
        max_w = CW'(max_bytes);
    end

    // Event classification with clipping of an over-long IN reply.
    always_comb begin
        ev       = EV_TIMEOUT;
        xfer_len = '0;
        case (res_kind)
            RES_DATA: begin
                if (pclass == PK_IN) begin
                    if (len_w > max_w) begin
                        ev       = EV_BABBLE;
                        xfer_len = max_bytes;
                    end else begin
                        ev       = EV_OK;
                        xfer_len = LW'(res_len);
                    end
                end else begin
                    ev       = EV_OK;
                    xfer_len = max_bytes;
                end
            end
            RES_NAK:    ev = EV_NAK;
            RES_STALL:  ev = EV_STALL;
            RES_BABBLE: ev = EV_BABBLE;
            default:    ev = EV_TIMEOUT;
        endcase
    end
endmodule

// File: rtl/tdu_ctrl_update.sv
// Control word updater: applies one evaluated event to the control word,
// including the retry counter, and chooses outcome, mask and error flags.
// Assumes the event and length come from tdu_result_eval.
module tdu_ctrl_update
    import tdu_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic [CTRL_W-1:0] ctrl_in,
    input  pid_class_e        pclass,
    input  event_e            ev,
    input  logic [LW-1:0]     xfer_len,
    input  logic [LW-1:0]     max_bytes,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic [1:0]        int_mask,
    output outcome_e          outcome,
    output logic              host_err,
    output logic              usb_err
);
    localparam int EW = B_ERR_HI - B_ERR_LO + 1;
    logic          do_tmo;
    logic [EW-1:0] err_cnt;

    // Main update: outcome, mask and the status bits other than the counter.
    always_comb begin
        ctrl_out = ctrl_in;
        int_mask = {1'b0, ctrl_in[B_IOC]};
        outcome  = OC_HOLD;
        host_err = 1'b0;
        usb_err  = 1'b0;
        do_tmo   = 1'b0;
        err_cnt  = ctrl_in[B_ERR_HI:B_ERR_LO];
        if (!ctrl_in[B_ACTIVE]) begin
            outcome = OC_HOLD;
        end else if (pclass == PK_BAD) begin
            host_err = 1'b1;
            outcome  = OC_ABORT;
        end else begin
            if (ctrl_in[B_ISO]) ctrl_out[B_ACTIVE] = 1'b0;
            case (ev)
                EV_OK: begin
                    ctrl_out[LW-1:0]   = xfer_len - LW'(1);
                    ctrl_out[B_ACTIVE] = 1'b0;
                    if (pclass == PK_IN && ctrl_in[B_SPD] && xfer_len < max_bytes) begin
                        int_mask[1] = 1'b1;
                        outcome     = OC_HOLD;
                    end else begin
                        outcome = OC_ADVANCE;
                    end
                end
                EV_BABBLE: begin
                    ctrl_out[B_BABBLE] = 1'b1;
                    ctrl_out[B_STALL]  = 1'b1;
                    ctrl_out[B_ACTIVE] = 1'b0;
                    outcome            = OC_ABORT;
                end
                EV_STALL: begin
                    ctrl_out[B_STALL]  = 1'b1;
                    ctrl_out[B_ACTIVE] = 1'b0;
                    outcome            = OC_HOLD;
                end
                EV_NAK: begin
                    ctrl_out[B_NAK] = 1'b1;
                    do_tmo          = (pclass == PK_SETUP);
                    outcome         = OC_HOLD;
                end
                default: begin
                    do_tmo  = 1'b1;
                    outcome = OC_HOLD;
                end
            endcase
            // Retry counter: saturating decrement, exhaustion retires.
            if (do_tmo) begin
                ctrl_out[B_TMO] = 1'b1;
                if (err_cnt != '0) begin
                    err_cnt = err_cnt - EW'(1);
                    if (err_cnt == '0) begin
                        ctrl_out[B_ACTIVE] = 1'b0;
                        usb_err            = 1'b1;
                    end
                end
                ctrl_out[B_ERR_HI:B_ERR_LO] = err_cnt;
            end
        end
    end
endmodule

// File: rtl/tdu_status_update.sv
// Top: descriptor status updater. Decodes the token, evaluates the result,
// updates the control word and registers every output once.
// Assumes one descriptor per valid cycle, with no back-pressure.
module tdu_status_update
    import tdu_pkg::*;
#(
    parameter int LW  = LEN_W,
    parameter int RLW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       ctrl_in,
    input  logic [31:0]       token_in,
    input  logic [2:0]        res_kind,
    input  logic [RLW-1:0]    res_len,
    output logic              out_valid,
    output logic [31:0]       ctrl_out,
    output logic              ctrl_changed,
    output logic [1:0]        int_mask,
    output logic [1:0]        outcome,
    output logic              host_err,
    output logic              usb_err,
    output logic [7:0]        pid,
    output logic [6:0]        dev_addr,
    output logic [3:0]        endp,
    output logic [LW-1:0]     max_bytes
);
    logic [7:0]     d_pid;
    logic [6:0]     d_addr;
    logic [3:0]     d_endp;
    logic [LW-1:0]  d_max;
    pid_class_e     d_class;
    event_e         d_ev;
    logic [LW-1:0]  d_len;
    logic [31:0]    n_ctrl;
    logic [1:0]     n_mask;
    outcome_e       n_oc;
    logic           n_herr;
    logic           n_uerr;

    tdu_token_decode #(.LW(LW)) u_dec (
        .token     (token_in),
        .pid       (d_pid),
        .dev_addr  (d_addr),
        .endp      (d_endp),
        .max_bytes (d_max),
        .pclass    (d_class)
    );

    tdu_result_eval #(.LW(LW), .RLW(RLW)) u_eval (
        .pclass    (d_class),
        .res_kind  (res_kind),
        .res_len   (res_len),
        .max_bytes (d_max),
        .ev        (d_ev),
        .xfer_len  (d_len)
    );

    tdu_ctrl_update #(.LW(LW)) u_upd (
        .ctrl_in   (ctrl_in),
        .pclass    (d_class),
        .ev        (d_ev),
        .xfer_len  (d_len),
        .max_bytes (d_max),
        .ctrl_out  (n_ctrl),
        .int_mask  (n_mask),
        .outcome   (n_oc),
        .host_err  (n_herr),
        .usb_err   (n_uerr)
    );

    // Output register stage; data is captured only on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            ctrl_out     <= '0;
            ctrl_changed <= 1'b0;
            int_mask     <= '0;
            outcome      <= '0;
            host_err     <= 1'b0;
            usb_err      <= 1'b0;
            pid          <= '0;
            dev_addr     <= '0;
            endp         <= '0;
            max_bytes    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ctrl_out     <= n_ctrl;
                ctrl_changed <= (n_ctrl != ctrl_in);
                int_mask     <= n_mask;
                outcome      <= n_oc;
                host_err     <= n_herr;
                usb_err      <= n_uerr;
                pid          <= d_pid;
                dev_addr     <= d_addr;
                endp         <= d_endp;
                max_bytes    <= d_max;
            end
        end
    end
endmodule

// File: rtl/tdu_status_update_chk.sv
// Checker: temporal properties of the status updater, relating registered
// outputs to the inputs of the previous cycle. Bound to the top below.
module tdu_status_update_chk
    import tdu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] ctrl_in,
    input logic        out_valid,
    input logic [31:0] ctrl_out,
    input logic        ctrl_changed,
    input logic [1:0]  int_mask,
    input logic [1:0]  outcome,
    input logic        host_err,
    input logic        usb_err
);
    a_r14_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r14_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r13_changed_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ctrl_changed == (ctrl_out != $past(ctrl_in))));
    a_r3_ioc_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(ctrl_in[B_IOC])) |-> int_mask[0]);
    a_r4_inactive_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(ctrl_in[B_ACTIVE])) |-> (ctrl_out == $past(ctrl_in) && outcome == OC_HOLD));
    a_r5_bad_pid_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && host_err) |-> (outcome == OC_ABORT && !ctrl_changed));
    a_r12_iso_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !host_err && $past(ctrl_in[B_ISO])) |-> !ctrl_out[B_ACTIVE]);
    a_r9_usb_err_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && usb_err) |-> (!ctrl_out[B_ACTIVE] && outcome == OC_HOLD));
    a_r7_advance_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && outcome == OC_ADVANCE) |-> !ctrl_out[B_ACTIVE]);
endmodule

bind tdu_status_update tdu_status_update_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .ctrl_in      (ctrl_in),
    .out_valid    (out_valid),
    .ctrl_out     (ctrl_out),
    .ctrl_changed (ctrl_changed),
    .int_mask     (int_mask),
    .outcome      (outcome),
    .host_err     (host_err),
    .usb_err      (usb_err)
);

// File: tb/tdu_status_update_test.sv
`timescale 1ns/1ps
module tdu_status_update_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] ctrl_in = '0;
    logic [31:0] token_in = '0;
    logic [2:0]  res_kind = '0;
    logic [11:0] res_len = '0;
    logic        out_valid;
    logic [31:0] ctrl_out;
    logic        ctrl_changed;
    logic [1:0]  int_mask;
    logic [1:0]  outcome;
    logic        host_err;
    logic        usb_err;
    logic [7:0]  pid;
    logic [6:0]  dev_addr;
    logic [3:0]  endp;
    logic [10:0] max_bytes;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tdu_status_update uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl_in(ctrl_in),
        .token_in(token_in), .res_kind(res_kind), .res_len(res_len),
        .out_valid(out_valid), .ctrl_out(ctrl_out), .ctrl_changed(ctrl_changed),
        .int_mask(int_mask), .outcome(outcome), .host_err(host_err),
        .usb_err(usb_err), .pid(pid), .dev_addr(dev_addr), .endp(endp),
        .max_bytes(max_bytes)
    );

    localparam logic [1:0] ADV = 2'd0, HOLD = 2'd1, ABRT = 2'd2;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tok(input logic [7:0] p, input logic [6:0] a,
                                        input logic [3:0] e, input logic [10:0] mf);
        return {mf, 2'b00, e, a, p};
    endfunction

    // Present one descriptor; outputs register at the next edge, sampled after it.
    task automatic apply(input logic [31:0] c, input logic [31:0] t,
                         input logic [2:0] k, input logic [11:0] l);
        @(negedge clk);
        ctrl_in = c; token_in = t; res_kind = k; res_len = l; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [31:0] c, input logic ch,
                              input logic [1:0] m, input logic [1:0] oc,
                              input logic he, input logic ue);
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " ctrl"}, ctrl_out, c);
        chk({req, " R13 changed"}, 32'(ctrl_changed), 32'(ch));
        chk({req, " mask"}, 32'(int_mask), 32'(m));
        chk({req, " outcome"}, 32'(outcome), 32'(oc));
        chk({req, " host_err"}, 32'(host_err), 32'(he));
        chk({req, " usb_err"}, 32'(usb_err), 32'(ue));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R14 reset valid", 32'(out_valid), 32'd0);
        chk("R14 reset ctrl", ctrl_out, 32'd0);
        chk("R14 reset outcome", 32'(outcome), 32'd0);
    endtask

    task automatic t_decode;
        apply(32'h0, tok(8'h69, 7'h55, 4'hA, 11'd7), 3'd0, 12'd0);
        chk("R1 pid", 32'(pid), 32'h69);
        chk("R1 addr", 32'(dev_addr), 32'h55);
        chk("R1 endp", 32'(endp), 32'hA);
        chk("R2 max", 32'(max_bytes), 32'd8);
        apply(32'h0, tok(8'h2D, 7'h7F, 4'hF, 11'h7FF), 3'd0, 12'd0);
        chk("R2 max wrap", 32'(max_bytes), 32'd0);
        chk("R1 addr ones", 32'(dev_addr), 32'h7F);
        chk("R14 idle", 32'(out_valid), 32'd1);
        @(negedge clk);
        chk("R14 idle after", 32'(out_valid), 32'd0);
    endtask

    task automatic t_inactive;
        apply(32'h0100_0005, tok(8'h69, 7'd1, 4'd1, 11'd7), 3'd0, 12'd3);
        expect_res("R3 R4 inactive ioc", 32'h0100_0005, 1'b0, 2'b01, HOLD, 1'b0, 1'b0);
    endtask

    task automatic t_success;
        apply(32'h1880_0000, tok(8'hE1, 7'd2, 4'd0, 11'd7), 3'd0, 12'd0);
        expect_res("R6 out ok", 32'h1800_0007, 1'b1, 2'b00, ADV, 1'b0, 1'b0);
        apply(32'h0080_0000, tok(8'h69, 7'd2, 4'd0, 11'h7FF), 3'd0, 12'd0);
        expect_res("R6 R2 zero len", 32'h0000_07FF, 1'b1, 2'b00, ADV, 1'b0, 1'b0);
        apply(32'h0080_0000, tok(8'h69, 7'd2, 4'd0, 11'd7), 3'd0, 12'd8);
        expect_res("R6 in full", 32'h0000_0007, 1'b1, 2'b00, ADV, 1'b0, 1'b0);
    endtask

    task automatic t_short;
        apply(32'h2080_0000, tok(8'h69, 7'd3, 4'd1, 11'd7), 3'd0, 12'd3);
        expect_res("R7 short spd", 32'h2000_0002, 1'b1, 2'b10, HOLD, 1'b0, 1'b0);
        apply(32'h0080_0000, tok(8'h69, 7'd3, 4'd1, 11'd7), 3'd0, 12'd3);
        expect_res("R7 short no spd", 32'h0000_0002, 1'b1, 2'b00, ADV, 1'b0, 1'b0);
        apply(32'h2080_0000, tok(8'h69, 7'd3, 4'd1, 11'd7), 3'd0, 12'd8);
        expect_res("R7 spd full", 32'h2000_0007, 1'b1, 2'b00, ADV, 1'b0, 1'b0);
    endtask

    task automatic t_babble;
        apply(32'h0080_0000, tok(8'h69, 7'd4, 4'd2, 11'd7), 3'd0, 12'd9);
        expect_res("R8 overlong", 32'h0050_0000, 1'b1, 2'b00, ABRT, 1'b0, 1'b0);
        apply(32'h0080_0000, tok(8'hE1, 7'd4, 4'd2, 11'd7), 3'd4, 12'd0);
        expect_res("R8 babble code", 32'h0050_0000, 1'b1, 2'b00, ABRT, 1'b0, 1'b0);
    endtask

    task automatic t_timeout;
        apply(32'h1880_0000, tok(8'h69, 7'd5, 4'd3, 11'd7), 3'd3, 12'd0);
        expect_res("R9 err3", 32'h1084_0000, 1'b1, 2'b00, HOLD, 1'b0, 1'b0);
        apply(32'h0880_0000, tok(8'h69, 7'd5, 4'd3, 11'd7), 3'd3, 12'd0);
        expect_res("R9 err1", 32'h0004_0000, 1'b1, 2'b00, HOLD, 1'b0, 1'b1);
        apply(32'h0080_0000, tok(8'h69, 7'd5, 4'd3, 11'd7), 3'd7, 12'd0);
        expect_res("R9 err0 unlimited", 32'h0084_0000, 1'b1, 2'b00, HOLD, 1'b0, 1'b0);
    endtask

    task automatic t_nak;
        apply(32'h1880_0000, tok(8'h69, 7'd6, 4'd4, 11'd7), 3'd1, 12'd0);
        expect_res("R10 nak in", 32'h1888_0000, 1'b1, 2'b00, HOLD, 1'b0, 1'b0);
        apply(32'h0880_0000, tok(8'h2D, 7'd6, 4'd4, 11'd7), 3'd1, 12'd0);
        expect_res("R10 nak setup", 32'h000C_0000, 1'b1, 2'b00, HOLD, 1'b0, 1'b1);
    endtask

    task automatic t_stall;
        apply(32'h1880_0000, tok(8'hE1, 7'd7, 4'd5, 11'd7), 3'd2, 12'd0);
        expect_res("R11 stall", 32'h1840_0000, 1'b1, 2'b00, HOLD, 1'b0, 1'b0);
    endtask

    task automatic t_iso;
        apply(32'h1A80_0000, tok(8'h69, 7'd8, 4'd6, 11'd7), 3'd1, 12'd0);
        expect_res("R12 iso nak", 32'h1A08_0000, 1'b1, 2'b00, HOLD, 1'b0, 1'b0);
    endtask

    task automatic t_badpid;
        apply(32'h0180_0000, tok(8'h00, 7'd9, 4'd7, 11'd7), 3'd0, 12'd0);
        expect_res("R5 bad pid", 32'h0180_0000, 1'b0, 2'b01, ABRT, 1'b1, 1'b0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_decode();
        t_inactive();
        t_success();
        t_short();
        t_babble();
        t_timeout();
        t_nak();
        t_stall();
        t_iso();
        t_badpid();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule